// File: doc/BRIEF.md
# Prioritised Two-Class Interrupt Controller

This block gathers 32 peripheral interrupt sources and presents them to a processor core on two request lines. One line is the normal interrupt and the other is the fast interrupt. Software reaches it over a simple 16-bit register bus. Through that bus it can read and clear pending bits, mask sources, and give each source a level word. The level word holds a 5-bit priority, a choice of edge or level capture, and routing to either request class.

For each class the controller picks the most urgent source that is pending, unmasked and routed to that class. It latches that source's number and raises the class's request line. The choice then stays frozen until software writes the class's acknowledge bit in the control register, which opens a new round. Every source input passes through a two-flop synchronizer before capture. A pending bit is recorded even while its source is masked.

Top module: `prio_intc`

## Requirements
- R1: After reset every mask bit reads 1 (0xFFFF at offsets 0x08 and 0x0A). All pending bits, level words and winner numbers read 0, and both request lines are low.
- R2: A source whose level word has bit 1 set (edge mode) sets its pending bit on a synchronised 0-to-1 input transition. Holding the input high after software clears the bit does not set it again.
- R3: A source with level-word bit 1 clear (level mode) keeps its pending bit set while its synchronised input is high, even against a software clear. Once the input is low, a clear takes effect.
- R4: Writing a pending register (offset 0x00 for sources 0–15, 0x02 for sources 16–31, source n at bit n mod 16) clears each bit written as 0 and leaves each bit written as 1 unchanged. Writing 0 clears the whole word.
- R5: A mask bit of 1 (offset 0x08 for sources 0–15, 0x0A for 16–31, same bit order) keeps the source out of arbitration but not out of its pending register. Clearing the mask lets it compete.
- R6: The level word of source n sits at offset 0x20 + 2·n. Bit 0 routes the source to the fast class, bit 1 selects edge mode, and bits 6:2 hold the priority. Bits 15:7 read as 0.
- R7: Within a class, the smaller priority value wins. On equal priority the lower source number wins.
- R8: The latched normal-class winner reads at offset 0x10 and the fast-class winner at offset 0x12, each in bits 4:0. Each class considers only sources routed to it.
- R9: While a class's request is high and no acknowledge for it is written, its request line and winner number stay unchanged, even when new and more urgent events arrive.
- R10: Writing the control register at offset 0x14 with bit 0 set acknowledges the normal class, and with bit 1 set acknowledges the fast class. The acknowledged class drops its request on the next cycle and then arbitrates again, while the other class is unaffected.
- R11: A request line is high exactly when its class holds a latched winner. After an acknowledge with no eligible source, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Raw peripheral interrupt inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the offset |
| irq_req_o | output | 1 | Normal-class request to the core |
| fiq_req_o | output | 1 | Fast-class request to the core |

## Verification
The bench targets a tie in priority between two sources, where a design that scanned from the top would report the higher-numbered source. It also checks that a more urgent event arriving while a winner is latched leaves the winner number unchanged, since a design that did not freeze would switch to the new source mid-service. Edge-mode sources are held high across a software clear to catch a detector that re-arms on level. Level-mode sources are cleared while still high to catch a clear that beats the input. Finally, acknowledging one class while the other holds a winner exposes an acknowledge decode that touches both classes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W = 5;

  // per-source level word, packed so bit 0 is the class route
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              edge_md;
    logic              to_fiq;
  } lvl_t;

  typedef enum logic {
    CLS_IRQ = 1'b0,
    CLS_FIQ = 1'b1
  } cls_e;

  localparam logic [7:0] OFS_PEND    = 8'h00;
  localparam logic [7:0] OFS_MASK    = 8'h08;
  localparam logic [7:0] OFS_WIN_IRQ = 8'h10;
  localparam logic [7:0] OFS_WIN_FIQ = 8'h12;
  localparam logic [7:0] OFS_CTRL    = 8'h14;
  localparam logic [7:0] OFS_LVL     = 8'h20;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_o = sr_q[1];
endmodule

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic [NUM_SRC-1:0]   edge_v,
  input  logic [NUM_SRC/DATA_W-1:0] pend_we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_SRC-1:0]   pend_o
);
  localparam int WORDS = NUM_SRC / DATA_W;

  logic [NUM_SRC-1:0] s1_q, s2_q, s3_q;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [NUM_SRC-1:0] set_v, clr_v;

  // a write of 0 clears, a write of 1 leaves the bit alone
  for (genvar w = 0; w < WORDS; w++) begin : g_clr
    assign clr_v[w*DATA_W +: DATA_W] = pend_we[w] ? ~wdata : '0;
  end

  // capture has priority over a software clear in the same cycle
  always_comb begin
    set_v  = (edge_v & s2_q & ~s3_q) | (~edge_v & s2_q);
    pend_d = set_v | (pend_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      pend_q <= '0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_class_arb.sv
module intc_class_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 5,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               cand_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_i,
  input  logic                             ack_i,
  output logic                             req_o,
  output logic [ID_W-1:0]                  num_o
);
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [ID_W-1:0]   best_i;
  logic              valid_q, valid_d;
  logic [ID_W-1:0]   num_q, num_d;
  logic              latch_en;

  // upward scan with strict compare: ties keep the lower index
  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (!found || prio_i[i] < best_p)) begin
        found  = 1'b1;
        best_p = prio_i[i];
        best_i = ID_W'(i);
      end
    end
  end

  // a class with no latched winner is open for arbitration
  always_comb begin
    latch_en = !valid_q && found && !ack_i;
    valid_d  = valid_q;
    num_d    = num_q;
    if (ack_i) begin
      valid_d = 1'b0;
    end else if (latch_en) begin
      valid_d = 1'b1;
      num_d   = best_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (latch_en) num_q <= num_d;
    end
  end

  assign req_o = valid_q;
  assign num_o = num_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_req_o,
  output logic               fiq_req_o
);
  import intc_pkg::*;

  localparam int WORDS    = NUM_SRC / DATA_W;
  localparam int ID_W     = $clog2(NUM_SRC);
  localparam int LVL_BASE = int'(OFS_LVL);
  localparam int LVL_END  = LVL_BASE + 2 * NUM_SRC;
  localparam int LVL_W    = $bits(lvl_t);

  logic rst_n_s;

  intc_rst_sync i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  // ---------------- write decode ----------------
  logic              wr_en;
  logic [WORDS-1:0]  pend_we, mask_we;
  logic              lvl_hit, lvl_we, ctrl_we;
  logic [ADDR_W-1:0] lvl_off;
  logic [ID_W-1:0]   lvl_idx;
  logic [1:0]        ack_v;

  assign wr_en = bus_sel && bus_wr;

  for (genvar w = 0; w < WORDS; w++) begin : g_wdec
    assign pend_we[w] = wr_en && (bus_addr == ADDR_W'(int'(OFS_PEND) + 2 * w));
    assign mask_we[w] = wr_en && (bus_addr == ADDR_W'(int'(OFS_MASK) + 2 * w));
  end

  assign lvl_off = bus_addr - ADDR_W'(LVL_BASE);
  assign lvl_idx = ID_W'(lvl_off >> 1);
  assign lvl_hit = (bus_addr >= ADDR_W'(LVL_BASE)) && (bus_addr < ADDR_W'(LVL_END))
                   && !bus_addr[0];
  assign lvl_we  = wr_en && lvl_hit;
  assign ctrl_we = wr_en && (bus_addr == ADDR_W'(OFS_CTRL));
  assign ack_v   = ctrl_we ? bus_wdata[1:0] : 2'b00;

  // ---------------- configuration registers ----------------
  logic [NUM_SRC-1:0]            mask_q, mask_d;
  lvl_t [NUM_SRC-1:0]            lvl_q;
  lvl_t                          lvl_d;
  logic                          mask_en;

  always_comb begin
    mask_d = mask_q;
    for (int w = 0; w < WORDS; w++) begin
      if (mask_we[w]) mask_d[w*DATA_W +: DATA_W] = bus_wdata;
    end
    mask_en = |mask_we;
    lvl_d   = lvl_t'(bus_wdata[LVL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mask_q <= '1;
      lvl_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (lvl_we)  lvl_q[lvl_idx] <= lvl_d;
    end
  end

  // ---------------- per-source fields ----------------
  logic [NUM_SRC-1:0]             edge_v, fiq_v;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_v;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fld
    assign edge_v[i] = lvl_q[i].edge_md;
    assign fiq_v[i]  = lvl_q[i].to_fiq;
    assign prio_v[i] = lvl_q[i].prio;
  end

  // ---------------- capture ----------------
  logic [NUM_SRC-1:0] pend_q;

  intc_capture #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) i_capture (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .src_i   (src_i),
    .edge_v  (edge_v),
    .pend_we (pend_we),
    .wdata   (bus_wdata),
    .pend_o  (pend_q)
  );

  // ---------------- per-class arbitration ----------------
  logic [1:0][NUM_SRC-1:0] cand_v;
  logic [1:0]              req_v;
  logic [1:0][ID_W-1:0]    num_v;

  for (genvar c = 0; c < 2; c++) begin : g_cls
    localparam cls_e CLS = cls_e'(c);
    if (CLS == CLS_FIQ) begin : g_fast
      assign cand_v[c] = pend_q & ~mask_q & fiq_v;
    end else begin : g_norm
      assign cand_v[c] = pend_q & ~mask_q & ~fiq_v;
    end

    intc_class_arb #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W)
    ) i_arb (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .cand_i (cand_v[c]),
      .prio_i (prio_v),
      .ack_i  (ack_v[c]),
      .req_o  (req_v[c]),
      .num_o  (num_v[c])
    );
  end

  assign irq_req_o = req_v[CLS_IRQ];
  assign fiq_req_o = req_v[CLS_FIQ];

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      for (int w = 0; w < WORDS; w++) begin
        if (bus_addr == ADDR_W'(int'(OFS_PEND) + 2 * w)) bus_rdata = pend_q[w*DATA_W +: DATA_W];
        if (bus_addr == ADDR_W'(int'(OFS_MASK) + 2 * w)) bus_rdata = mask_q[w*DATA_W +: DATA_W];
      end
      if (bus_addr == ADDR_W'(OFS_WIN_IRQ)) bus_rdata = DATA_W'(num_v[CLS_IRQ]);
      if (bus_addr == ADDR_W'(OFS_WIN_FIQ)) bus_rdata = DATA_W'(num_v[CLS_FIQ]);
      if (lvl_hit) bus_rdata = DATA_W'(lvl_q[lvl_idx]);
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [1:0]         ack_bits,
  input logic               irq_req_o,
  input logic               fiq_req_o,
  input logic [ID_W-1:0]    num_irq,
  input logic [ID_W-1:0]    num_fiq,
  input logic [NUM_SRC-1:0] cand_irq,
  input logic [NUM_SRC-1:0] cand_fiq
);
  logic ctrl_wr, ack_irq, ack_fiq;
  logic [NUM_SRC-1:0] cand_irq_q, cand_fiq_q;

  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(8'h14));
  assign ack_irq = ctrl_wr && ack_bits[0];
  assign ack_fiq = ctrl_wr && ack_bits[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_irq_q <= '0;
      cand_fiq_q <= '0;
    end else begin
      cand_irq_q <= cand_irq;
      cand_fiq_q <= cand_fiq;
    end
  end

  // R1: both request lines are low while reset is applied
  always @(posedge clk) begin
    if (!rst_n) a_r1_idle_in_reset: assert (!irq_req_o && !fiq_req_o);
  end

  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o && !ack_irq |=> irq_req_o && $stable(num_irq));

  a_r9_fiq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_req_o && !ack_fiq |=> fiq_req_o && $stable(num_fiq));

  a_r10_irq_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> !irq_req_o);

  a_r10_fiq_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fiq |=> !fiq_req_o);

  // R5 / R11: a new normal-class winner was an eligible candidate
  a_r5_irq_from_cand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req_o) |-> cand_irq_q[num_irq]);

  // R8: a new fast-class winner was routed to the fast class and eligible
  a_r8_fiq_from_cand: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_req_o) |-> cand_fiq_q[num_fiq]);
endmodule

bind prio_intc intc_chk #(
  .NUM_SRC (NUM_SRC),
  .ADDR_W  (ADDR_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .ack_bits  (bus_wdata[1:0]),
  .irq_req_o (irq_req_o),
  .fiq_req_o (fiq_req_o),
  .num_irq   (num_v[0]),
  .num_fiq   (num_v[1]),
  .cand_irq  (cand_v[0]),
  .cand_fiq  (cand_v[1])
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [31:0] src = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_req, fiq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_intc i_prio_intc (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req_o (irq_req),
    .fiq_req_o (fiq_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input logic [31:0] bits);
    @(negedge clk); src = src | bits;
    settle(4);
    src = src & ~bits;
    settle(4);
  endtask

  function automatic logic [7:0] lvl_addr(input int n);
    return 8'(8'h20 + 2 * n);
  endfunction

  task automatic t_reset;
    rd_chk("R1 mask lo", 8'h08, 16'hFFFF);
    rd_chk("R1 mask hi", 8'h0A, 16'hFFFF);
    rd_chk("R1 pend lo", 8'h00, 16'h0000);
    rd_chk("R1 pend hi", 8'h02, 16'h0000);
    rd_chk("R1 level 31", lvl_addr(31), 16'h0000);
    rd_chk("R1 win irq", 8'h10, 16'h0000);
    check("R1 irq low", {15'd0, irq_req}, 16'h0000);
    check("R1 fiq low", {15'd0, fiq_req}, 16'h0000);
  endtask

  task automatic t_level_word;
    wr(lvl_addr(3), 16'hFFFF);
    rd_chk("R6 field readback", lvl_addr(3), 16'h007F);
    rd_chk("R6 neighbour untouched", lvl_addr(4), 16'h0000);
    wr(lvl_addr(3), 16'h0000);
    rd_chk("R6 cleared", lvl_addr(3), 16'h0000);
  endtask

  task automatic t_edge;
    wr(lvl_addr(4), 16'h0002);
    wr(lvl_addr(20), 16'h0002);
    @(negedge clk); src[4] = 1'b1; src[20] = 1'b1;
    settle(5);
    rd_chk("R2 edge sets lo", 8'h00, 16'h0010);
    rd_chk("R2 edge sets hi", 8'h02, 16'h0010);
    wr(8'h00, 16'hFFEF);
    settle(4);
    rd_chk("R2 no re-set while high", 8'h00, 16'h0000);
    wr(8'h02, 16'hFFFF);
    settle(2);
    rd_chk("R4 ones leave bits", 8'h02, 16'h0010);
    @(negedge clk); src[4] = 1'b0; src[20] = 1'b0;
    settle(4);
    wr(8'h02, 16'h0000);
    settle(2);
    rd_chk("R4 zero word clears", 8'h02, 16'h0000);
    check("R5 masked no irq", {15'd0, irq_req}, 16'h0000);
    wr(lvl_addr(4), 16'h0000);
    wr(lvl_addr(20), 16'h0000);
  endtask

  task automatic t_level_mode;
    @(negedge clk); src[7] = 1'b1;
    settle(5);
    rd_chk("R3 level sets", 8'h00, 16'h0080);
    wr(8'h00, 16'h0000);
    settle(3);
    rd_chk("R3 clear blocked while high", 8'h00, 16'h0080);
    @(negedge clk); src[7] = 1'b0;
    settle(4);
    wr(8'h00, 16'h0000);
    settle(2);
    rd_chk("R3 clear after low", 8'h00, 16'h0000);
  endtask

  task automatic t_mask;
    wr(lvl_addr(5), 16'h0002);
    pulse(32'h0000_0020);
    rd_chk("R5 masked still pends", 8'h00, 16'h0020);
    check("R5 masked no request", {15'd0, irq_req}, 16'h0000);
    wr(8'h08, 16'hFFDF);
    settle(3);
    check("R11 request on unmask", {15'd0, irq_req}, 16'h0001);
    rd_chk("R8 winner after unmask", 8'h10, 16'h0005);
    wr(8'h08, 16'hFFFF);
    wr(8'h00, 16'hFFDF);
    wr(8'h14, 16'h0001);
    settle(3);
    check("R11 no eligible stays low", {15'd0, irq_req}, 16'h0000);
    wr(lvl_addr(5), 16'h0000);
  endtask

  task automatic t_priority;
    wr(lvl_addr(1), 16'h0002);
    wr(lvl_addr(2), 16'h0026);
    wr(lvl_addr(9), 16'h000E);
    wr(lvl_addr(12), 16'h000E);
    pulse(32'h0000_1204);
    wr(8'h08, 16'hEDF9);
    settle(3);
    rd_chk("R7 tie picks lower number", 8'h10, 16'h0009);
    pulse(32'h0000_0002);
    rd_chk("R9 winner frozen", 8'h10, 16'h0009);
    check("R9 request held", {15'd0, irq_req}, 16'h0001);
    wr(8'h00, 16'hFDFF);
    wr(8'h14, 16'h0001);
    settle(3);
    rd_chk("R7 priority 0 wins", 8'h10, 16'h0001);
    wr(8'h00, 16'hFFFD);
    wr(8'h14, 16'h0001);
    settle(3);
    rd_chk("R7 prio 3 beats prio 9", 8'h10, 16'h000C);
    wr(8'h00, 16'hEFFF);
    wr(8'h14, 16'h0001);
    settle(3);
    rd_chk("R10 next round", 8'h10, 16'h0002);
    wr(8'h00, 16'hFFFB);
    wr(8'h14, 16'h0001);
    settle(3);
    check("R11 empty round low", {15'd0, irq_req}, 16'h0000);
    wr(8'h08, 16'hFFFF);
  endtask

  task automatic t_fast;
    wr(lvl_addr(25), 16'h0017);
    wr(lvl_addr(26), 16'h0016);
    pulse(32'h0600_0000);
    wr(8'h0A, 16'hF9FF);
    settle(3);
    check("R8 fiq raised", {15'd0, fiq_req}, 16'h0001);
    rd_chk("R8 fiq winner", 8'h12, 16'h0019);
    rd_chk("R8 irq winner", 8'h10, 16'h001A);
    wr(8'h02, 16'hFBFF);
    wr(8'h14, 16'h0001);
    settle(3);
    check("R10 irq acked", {15'd0, irq_req}, 16'h0000);
    check("R10 fiq untouched", {15'd0, fiq_req}, 16'h0001);
    rd_chk("R10 fiq winner kept", 8'h12, 16'h0019);
    wr(8'h02, 16'hFDFF);
    wr(8'h14, 16'h0002);
    settle(3);
    check("R10 fiq acked", {15'd0, fiq_req}, 16'h0000);
    wr(8'h0A, 16'hFFFF);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    settle(3);
    @(negedge clk) rst_n = 1'b1;
    settle(3);
    t_reset();
    t_level_word();
    t_edge();
    t_level_mode();
    t_mask();
    t_priority();
    t_fast();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule